// File: doc/BRIEF.md
# Last-Level Cache Error Capture Unit

This block sits beside a last-level cache and turns the error events the cache raises into status, a frozen record of the first failure, and two interrupt lines. Each cycle the cache may signal a correctable error, an uncorrectable error, a multiple-hit condition or a dropped eviction of a line that held an error. The correctable and uncorrectable events each carry their own bundle of capture information: syndrome, way, requesting agent, error group, operation type, bank, a data-or-tag flag and the 42-bit physical address of the failing line.

Software sees five 32-bit registers on a simple word-addressed bus: status, control, a log word, an address log and a bank log. The first error is recorded in the three log registers. Errors that follow while one is still pending only set sticky "repeat" flags, so the record of the first failure stays intact until software clears the status. A status write sets or clears bits directly, which also lets software inject errors to test its handler. The correctable and uncorrectable interrupts are each gated by their own enable bit. Detection can stay on while both interrupts are off.

Top module: `llc_err_capture`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: The registers sit at byte addresses 0x28 (status), 0x2C (control), 0x30 (log), 0x34 (address log) and 0x38 (bank log), which are word offsets 0x0A to 0x0E times 4. Control keeps bits [3:0] of a write. Every other address reads zero, and so does any access with bus_en low.
- R3: A correctable event with control bit 0 set raises status bit 0 (correctable pending) and bit 2 (correctable error). An uncorrectable event with control bit 1 set raises status bit 1 and bit 3. An event whose detection bit is clear changes nothing.
- R4: A capture bundle is packed MSB first as {syndrome[8:0], way[5:0], agent[3:0], group[3:0], optype[3:0], bank[3:0], data_flag, paddr[41:0]}, 74 bits in all. On capture the log register takes syndrome in [31:23], way in [22:17], agent in [16:13], group in [11:8], optype in [7:4] and paddr[41:38] in [3:0], with bit 12 zero. The address log takes paddr[37:6]. The bank log takes the bank in [3:0]. Status bit 9 takes the data flag.
- R5: Capture happens only when neither status bit 2 nor status bit 3 is set. Otherwise all three log registers and status bit 9 keep their values.
- R6: A correctable event while bit 2 is already set sets bit 4. An uncorrectable event while bit 3 is already set sets bit 5. These bits are sticky.
- R7: With control bit 1 set, a multiple-hit event sets status bit 8 and a dropped-eviction event sets status bit 6. Neither event captures a log or raises a pending bit.
- R8: When an enabled correctable event and an enabled uncorrectable event arrive in the same cycle and a capture is allowed, the log registers take the uncorrectable bundle.
- R9: ce_irq equals status bit 0 AND control bit 2. ue_irq equals status bit 1 AND control bit 3.
- R10: A status write stores wdata AND 0x37F. Writing zero clears the register and writing all ones sets every implemented bit. A status write takes priority over events in the same cycle. Writes to the three log registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ce | input | 1 | Correctable error event |
| ev_ue | input | 1 | Uncorrectable error event |
| ev_mhit | input | 1 | Multiple-hit event |
| ev_evict | input | 1 | Dropped eviction of an errored line |
| ce_info | input | 74 | Capture bundle for the correctable event |
| ue_info | input | 74 | Capture bundle for the uncorrectable event |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ce_irq | output | 1 | Correctable interrupt |
| ue_irq | output | 1 | Uncorrectable interrupt |

## Verification
The assertions assume that the event inputs and the bus inputs are stable around the clock edge. They also assume that a status write and a control write never share a cycle, since the bus carries one access per cycle. The stimulus changes all inputs on the falling edge and issues at most one bus write per cycle. It draws events, bundles and occasional clears or control rewrites from a fixed-seed random stream, with directed cases for the same-cycle conflict and for injection.

// File: rtl/llc_err_pkg.sv
package llc_err_pkg;
    localparam int SYN_W    = 9;
    localparam int WAY_W    = 6;
    localparam int AGT_W    = 4;
    localparam int GRP_W    = 4;
    localparam int OP_W     = 4;
    localparam int BANK_W   = 4;
    localparam int PA_W     = 42;
    localparam int LINE_OFS = 6;
    localparam int DATA_W   = 32;
    localparam int ALOG_W   = DATA_W;
    localparam int PA_HI_W  = PA_W - LINE_OFS - ALOG_W;
    localparam int INFO_W   = SYN_W + WAY_W + AGT_W + GRP_W + OP_W + BANK_W + 1 + PA_W;
    localparam int ST_W     = 10;
    localparam int CTRL_W   = 4;

    localparam logic [ST_W-1:0] ST_MASK = 10'h37F;

    // status bit positions
    localparam int S_CPEND = 0;
    localparam int S_UPEND = 1;
    localparam int S_CERR  = 2;
    localparam int S_UERR  = 3;
    localparam int S_CMULT = 4;
    localparam int S_UMULT = 5;
    localparam int S_EVICT = 6;
    localparam int S_MHIT  = 8;
    localparam int S_DATA  = 9;

    // register word offsets
    localparam int OFS_STAT = 10;
    localparam int OFS_CTRL = 11;
    localparam int OFS_LOG  = 12;
    localparam int OFS_ALOG = 13;
    localparam int OFS_BANK = 14;

    typedef struct packed {
        logic [SYN_W-1:0]  syn;
        logic [WAY_W-1:0]  way;
        logic [AGT_W-1:0]  agent;
        logic [GRP_W-1:0]  grp;
        logic [OP_W-1:0]   op;
        logic [BANK_W-1:0] bank;
        logic              is_data;
        logic [PA_W-1:0]   paddr;
    } cap_info_t;

    typedef struct packed {
        logic [ST_W-1:0]   st;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] log;
        logic [ALOG_W-1:0] alog;
        logic [BANK_W-1:0] bank;
    } err_regs_t;
endpackage

// File: rtl/llc_err_state.sv
module llc_err_state
    import llc_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic              ev_mhit,
    input  logic              ev_evict,
    input  cap_info_t         ce_info,
    input  cap_info_t         ue_info,
    input  logic              wr_stat,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output err_regs_t         regs_q
);
    err_regs_t regs_d;
    cap_info_t sel;
    logic      ce_hit, ue_hit, pend;

    always_comb begin
        regs_d = regs_q;
        ce_hit = ev_ce & regs_q.ctrl[0];
        ue_hit = ev_ue & regs_q.ctrl[1];
        pend   = regs_q.st[S_CERR] | regs_q.st[S_UERR];
        sel    = ue_hit ? ue_info : ce_info;

        if (wr_stat) begin
            regs_d.st = wdata[ST_W-1:0] & ST_MASK;
        end else begin
            if (ce_hit) begin
                regs_d.st[S_CPEND] = 1'b1;
                regs_d.st[S_CERR]  = 1'b1;
                if (regs_q.st[S_CERR]) regs_d.st[S_CMULT] = 1'b1;
            end
            if (ue_hit) begin
                regs_d.st[S_UPEND] = 1'b1;
                regs_d.st[S_UERR]  = 1'b1;
                if (regs_q.st[S_UERR]) regs_d.st[S_UMULT] = 1'b1;
            end
            if (ev_mhit  & regs_q.ctrl[1]) regs_d.st[S_MHIT]  = 1'b1;
            if (ev_evict & regs_q.ctrl[1]) regs_d.st[S_EVICT] = 1'b1;
            if ((ce_hit | ue_hit) & ~pend) begin
                regs_d.log = {sel.syn, sel.way, sel.agent, 1'b0, sel.grp, sel.op,
                              sel.paddr[PA_W-1 -: PA_HI_W]};
                regs_d.alog = sel.paddr[PA_W-PA_HI_W-1:LINE_OFS];
                regs_d.bank = sel.bank;
                regs_d.st[S_DATA] = sel.is_data;
            end
        end
        if (wr_ctrl) regs_d.ctrl = wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    a_r3_ce_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ce && regs_q.ctrl[0] && !wr_stat) |=> (regs_q.st[S_CPEND] && regs_q.st[S_CERR]));

    a_r3_ce_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.ctrl[0] && !wr_stat) |=>
        (regs_q.st[S_CERR] == $past(regs_q.st[S_CERR]) && regs_q.st[S_CMULT] == $past(regs_q.st[S_CMULT])));

    a_r5_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st[S_CERR] || regs_q.st[S_UERR]) |=>
        ($stable(regs_q.log) && $stable(regs_q.alog) && $stable(regs_q.bank)));

    a_r6_ue_multi: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ue && regs_q.ctrl[1] && regs_q.st[S_UERR] && !wr_stat) |=> regs_q.st[S_UMULT]);

    a_r8_ue_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ce && ev_ue && regs_q.ctrl[1:0] == 2'b11 && !regs_q.st[S_CERR] && !regs_q.st[S_UERR] && !wr_stat)
        |=> (regs_q.log[31:23] == $past(ue_info.syn) && regs_q.bank == $past(ue_info.bank)));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata == '0) |=> (regs_q.st == '0));
endmodule

// File: rtl/llc_err_rdmux.sv
module llc_err_rdmux
    import llc_err_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              rd_en,
    input  logic [WORD_W-1:0] word,
    input  err_regs_t         regs,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [WORD_W-1:0] W_STAT = WORD_W'(OFS_STAT);
    localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(OFS_CTRL);
    localparam logic [WORD_W-1:0] W_LOG  = WORD_W'(OFS_LOG);
    localparam logic [WORD_W-1:0] W_ALOG = WORD_W'(OFS_ALOG);
    localparam logic [WORD_W-1:0] W_BANK = WORD_W'(OFS_BANK);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (word)
                W_STAT:  rdata = DATA_W'(regs.st);
                W_CTRL:  rdata = DATA_W'(regs.ctrl);
                W_LOG:   rdata = regs.log;
                W_ALOG:  rdata = regs.alog;
                W_BANK:  rdata = DATA_W'(regs.bank);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/llc_err_capture.sv
module llc_err_capture
    import llc_err_pkg::*;
#(
    parameter int BUS_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic              ev_mhit,
    input  logic              ev_evict,
    input  logic [INFO_W-1:0] ce_info,
    input  logic [INFO_W-1:0] ue_info,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ce_irq,
    output logic              ue_irq
);
    localparam int WORD_W = BUS_AW - 2;
    localparam logic [WORD_W-1:0] W_STAT = WORD_W'(OFS_STAT);
    localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(OFS_CTRL);

    logic [WORD_W-1:0] word;
    logic              wr_stat, wr_ctrl;
    err_regs_t         regs;

    assign word    = bus_addr[BUS_AW-1:2];
    assign wr_stat = bus_en & bus_we & (word == W_STAT);
    assign wr_ctrl = bus_en & bus_we & (word == W_CTRL);

    llc_err_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_ce    (ev_ce),
        .ev_ue    (ev_ue),
        .ev_mhit  (ev_mhit),
        .ev_evict (ev_evict),
        .ce_info  (cap_info_t'(ce_info)),
        .ue_info  (cap_info_t'(ue_info)),
        .wr_stat  (wr_stat),
        .wr_ctrl  (wr_ctrl),
        .wdata    (bus_wdata),
        .regs_q   (regs)
    );

    llc_err_rdmux #(.WORD_W(WORD_W)) u_rdmux (
        .rd_en (bus_en & ~bus_we),
        .word  (word),
        .regs  (regs),
        .rdata (bus_rdata)
    );

    assign ce_irq = regs.st[S_CPEND] & regs.ctrl[2];
    assign ue_irq = regs.st[S_UPEND] & regs.ctrl[3];

    a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && word == W_STAT && bus_wdata == '0) |=> (!ce_irq && !ue_irq));
endmodule

// File: tb/llc_err_capture_tb.sv
module llc_err_capture_tb;
    localparam int IW = 74;
    localparam logic [7:0] A_ST = 8'h28, A_CT = 8'h2C, A_LG = 8'h30, A_AL = 8'h34, A_BK = 8'h38;

    logic clk = 0, rst_n = 0;
    logic ev_ce = 0, ev_ue = 0, ev_mhit = 0, ev_evict = 0;
    logic [IW-1:0] ce_info = '0, ue_info = '0;
    logic bus_en = 0, bus_we = 0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic ce_irq, ue_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m_st = 0, m_ct = 0, m_lg = 0, m_al = 0, m_bk = 0;

    llc_err_capture u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [IW-1:0] mk_info();
        return {$urandom(), $urandom(), 10'($urandom())};
    endfunction

    // expected next state from the requirements
    task automatic model(bit ce, bit ue, bit mh, bit ev, logic [IW-1:0] ci, logic [IW-1:0] ui,
                         bit wst, bit wct, logic [31:0] wd);
        logic [31:0] st = m_st;
        bit ceh = ce & m_ct[0], ueh = ue & m_ct[1];
        logic [IW-1:0] s = ueh ? ui : ci;
        if (wst) st = wd & 32'h37F;
        else begin
            if (ceh) begin st[0] = 1; st[2] = 1; if (m_st[2]) st[4] = 1; end
            if (ueh) begin st[1] = 1; st[3] = 1; if (m_st[3]) st[5] = 1; end
            if (mh && m_ct[1]) st[8] = 1;
            if (ev && m_ct[1]) st[6] = 1;
            if ((ceh || ueh) && !m_st[2] && !m_st[3]) begin
                m_lg = {s[73:65], s[64:59], s[58:55], 1'b0, s[54:51], s[50:47], s[41:38]};
                m_al = s[37:6];
                m_bk = {28'd0, s[46:43]};
                st[9] = s[42];
            end
        end
        if (wct) m_ct = {28'd0, wd[3:0]};
        m_st = st;
    endtask

    task automatic cyc(bit ce, bit ue, bit mh, bit ev, logic [IW-1:0] ci, logic [IW-1:0] ui,
                       bit wst, bit wct, logic [31:0] wd, logic [7:0] wa = A_ST);
        @(negedge clk);
        ev_ce = ce; ev_ue = ue; ev_mhit = mh; ev_evict = ev; ce_info = ci; ue_info = ui;
        bus_en = wst | wct | (wa != A_ST && wa != A_CT); bus_we = 1;
        bus_addr = wct ? A_CT : (wst ? A_ST : wa); bus_wdata = wd;
        @(posedge clk);
        model(ce, ue, mh, ev, ci, ui, wst, wct, wd);
        @(negedge clk);
        ev_ce = 0; ev_ue = 0; ev_mhit = 0; ev_evict = 0; bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #0.5 d = bus_rdata;
        bus_en = 0;
        #0.1;
    endtask

    task automatic cmp_all(string req);
        logic [31:0] d;
        rd(A_ST, d); chk({req, " status"}, d, m_st);
        rd(A_CT, d); chk({req, " control"}, d, m_ct);
        rd(A_LG, d); chk({req, " log"}, d, m_lg);
        rd(A_AL, d); chk({req, " addr log"}, d, m_al);
        rd(A_BK, d); chk({req, " bank log"}, d, m_bk);
        chk({req, " R9 ce_irq"}, 32'(ce_irq), 32'(m_st[0] & m_ct[2]));
        chk({req, " R9 ue_irq"}, 32'(ue_irq), 32'(m_st[1] & m_ct[3]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [IW-1:0] a, b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cmp_all("R1");
        chk("R1 ce_irq", 32'(ce_irq), 0);
        // R2 map and unmapped reads
        cyc(0,0,0,0,'0,'0,0,1,32'hFFFF_FFF5);
        rd(A_CT, d); chk("R2 control bits", d, 32'h5);
        rd(8'h00, d); chk("R2 unmapped", d, 0);
        rd(8'h3C, d); chk("R2 unmapped above", d, 0);
        // R3 disabled detection ignored
        cyc(0,0,0,0,'0,'0,0,1,32'h0);
        cyc(1,1,1,1,mk_info(),mk_info(),0,0,0);
        rd(A_ST, d); chk("R3 disabled ignored", d, 0);
        cmp_all("R3");
        // R4 first capture with known bundle
        cyc(0,0,0,0,'0,'0,0,1,32'hF);
        a = {9'h1A5, 6'h2B, 4'h9, 4'h6, 4'h3, 4'hC, 1'b1, 42'h2AB_CDEF_0123};
        cyc(1,0,0,0,a,'0,0,0,0);
        rd(A_LG, d); chk("R4 log layout", d, {9'h1A5, 6'h2B, 4'h9, 1'b0, 4'h6, 4'h3, 4'hA});
        rd(A_AL, d); chk("R4 addr log", d, 32'hAF37_BC04);
        rd(A_BK, d); chk("R4 bank log", d, 32'hC);
        rd(A_ST, d); chk("R4 status", d, 32'h205);
        chk("R9 ce_irq on", 32'(ce_irq), 1);
        // R5/R6 repeats do not overwrite
        b = mk_info();
        cyc(1,0,0,0,b,'0,0,0,0);
        cyc(0,1,0,0,'0,b,0,0,0);
        cyc(0,1,0,0,'0,b,0,0,0);
        rd(A_ST, d); chk("R6 multiple flags", d, 32'h23F);
        cmp_all("R5");
        // R10 clear
        cyc(0,0,0,0,'0,'0,1,0,32'h0);
        cmp_all("R10 clear");
        // R8 same-cycle UE wins
        a = mk_info(); b = mk_info();
        cyc(1,1,0,0,a,b,0,0,0);
        rd(A_BK, d); chk("R8 ue bank", d, {28'd0, b[46:43]});
        cmp_all("R8");
        // R7 mhit / evict
        cyc(0,0,0,0,'0,'0,1,0,32'h0);
        cyc(0,0,1,1,mk_info(),mk_info(),0,0,0);
        rd(A_ST, d); chk("R7 mhit evict", d, 32'h140);
        // R10 inject, log unchanged, write priority
        cyc(1,1,0,0,mk_info(),mk_info(),1,0,32'hFFFF_FFFF);
        rd(A_ST, d); chk("R10 inject", d, 32'h37F);
        cmp_all("R10 inject");
        cyc(0,0,0,0,'0,'0,0,0,32'h1234, A_LG);
        cmp_all("R10 log read-only");
        // R9 interrupts off while pending
        cyc(0,0,0,0,'0,'0,0,1,32'h3);
        chk("R9 irq gated ce", 32'(ce_irq), 0);
        chk("R9 irq gated ue", 32'(ue_irq), 0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 99));
            bit wst = (r < 6);
            bit wct = (r >= 6 && r < 10);
            logic [31:0] wd = (r < 3) ? 32'h0 : $urandom();
            cyc($urandom_range(0,3) == 0, $urandom_range(0,4) == 0, $urandom_range(0,9) == 0,
                $urandom_range(0,9) == 0, mk_info(), mk_info(), wst, wct, wd);
            cmp_all("R3-R10 random");
        end
        finish_run();
    end
endmodule